// File: doc/BRIEF.md
# Gamma Palette Register Write Port

This block is the register-side loader for a segmented gamma curve. Software writes 32-bit words over a simple register bus. The block builds 48-bit palette entries from those words and drives them onto the write side of two storage arrays. A gamma evaluator elsewhere reads those arrays. Each entry holds a 16-bit value for red, green and blue in 12.4 interpolated form.

Each entry arrives as two data writes: first a word with the six low bits of every channel, then a word with the ten high bits. The entry is committed only when the second word lands. If the order is swapped, the channels come out scrambled, so the block always treats the first word after an index write as the low half.

There are two tables, and each has its own index register and data register.
- The superfine table is small (nine entries).
- The main table holds the fine segment followed directly by the coarse segment. Fine entry 0 is never used, so main index 0 addresses storage location 1. A full stream of fine entries runs on into the coarse entries without rewriting the index.

Three separate 16-bit registers hold the curve endpoint for each channel.

Top module: `gamma_pal_wport`

## Requirements
- R1: After reset, every register reads 0, both auto-increment flags are clear, the endpoint outputs are 0 and no write strobe is active.
- R2: The first data write of a pair supplies the low six bits of each channel: red from bits 29:24, green from 19:14, blue from 9:4. The second write supplies the high ten bits: red from 29:20, green from 19:10, blue from 9:0. Each channel is {high10, low6}, and the entry is {red, green, blue} with red in bits 47:32. Bits outside these fields are ignored.
- R3: Only the second data write of a pair produces a write strobe. The strobe is high for exactly one cycle, starting the cycle after that write, with address and data valid alongside it. The first write produces no strobe.
- R4: An index register write takes the index from its low bits and the auto-increment flag from bit 31. With the flag set, the index advances by one after each completed pair.
- R5: With the auto-increment flag clear, the index stays where it is, and repeated pairs rewrite the same storage location.
- R6: Writing an index register resets that table's half-entry tracker, so the next data write is taken as a low-bits word.
- R7: The superfine table has 9 entries at storage addresses 0..8 (register offset 0 is the index, offset 1 is the data). Under auto-increment, index 8 wraps to 0. An index write above 8 is clamped to 8.
- R8: Main table (offset 2 is the index, offset 3 is the data). Index i writes storage address i+1. A stream of 512 pairs starting from index 0 fills fine addresses 1..256 and then coarse addresses 257..512. The index then wraps to 0.
- R9: The red, green and blue endpoint registers sit at offsets 4, 5 and 6. Each keeps bits 15:0 of the written word and drives its own 16-bit output. The upper bits are ignored and read back as 0.
- R10: Readback layout:
  - An index register reads the auto-increment flag in bit 31 and the index in its low bits.
  - A data register reads the upper ten bits of each channel of the last completed entry, in the high-word layout.
  - Unused bits and unmapped offsets read 0, and writes to unmapped offsets change nothing.
- R11: The two tables track their half-entry state independently, so interleaved writes to both tables still form correct entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sf_we | output | 1 | Superfine storage write strobe |
| sf_waddr | output | 4 | Superfine storage address |
| sf_wdata | output | 48 | Superfine entry {red, green, blue} |
| mt_we | output | 1 | Main storage write strobe |
| mt_waddr | output | 10 | Main storage address (1..512) |
| mt_wdata | output | 48 | Main entry {red, green, blue} |
| max_r | output | 16 | Red endpoint value |
| max_g | output | 16 | Green endpoint value |
| max_b | output | 16 | Blue endpoint value |

## Verification
Random 48-bit entries are split into low and high words with random junk in the unused bits. This separates correct field extraction from leakage of ignored bits, and it shows whether the two halves were joined in the right order.

Long auto-increment streams through each table test the address mapping:
- The superfine stream checks the wrap from 8 to 0.
- The full 512-pair main stream checks the skipped fine entry 0 and the seamless fine-to-coarse crossover.

Directed cases cover several conditions:
- a fixed index with auto-increment off;
- a stray single word followed by an index write;
- pairs interleaved across the two tables;
- clamped index writes;
- unmapped offsets.

Each of these conditions would show up as a wrong address or a wrong entry.

// File: rtl/gamma_pal_wport.sv
module gamma_pal_wport #(
  parameter int SF_N     = 9,
  parameter int FINE_N   = 256,
  parameter int COARSE_N = 256,
  parameter int AW       = 4,
  parameter int SF_AW    = $clog2(SF_N),
  parameter int MT_AW    = $clog2(FINE_N + COARSE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              sf_we,
  output logic [SF_AW-1:0]  sf_waddr,
  output logic [47:0]       sf_wdata,
  output logic              mt_we,
  output logic [MT_AW-1:0]  mt_waddr,
  output logic [47:0]       mt_wdata,
  output logic [15:0]       max_r,
  output logic [15:0]       max_g,
  output logic [15:0]       max_b
);

  localparam int MT_N  = FINE_N + COARSE_N;
  localparam int MT_IW = $clog2(MT_N);
  localparam logic [SF_AW-1:0] SF_LAST = SF_AW'(SF_N - 1);
  localparam logic [MT_IW-1:0] MT_LAST = MT_IW'(MT_N - 1);

  localparam logic [AW-1:0] A_SF_IDX = AW'(0);
  localparam logic [AW-1:0] A_SF_DAT = AW'(1);
  localparam logic [AW-1:0] A_MT_IDX = AW'(2);
  localparam logic [AW-1:0] A_MT_DAT = AW'(3);
  localparam logic [AW-1:0] A_MAX_R  = AW'(4);
  localparam logic [AW-1:0] A_MAX_G  = AW'(5);
  localparam logic [AW-1:0] A_MAX_B  = AW'(6);

  function automatic logic [17:0] low_fields(input logic [31:0] w);
    return {w[29:24], w[19:14], w[9:4]};
  endfunction

  function automatic logic [47:0] join_entry(input logic [17:0] lo, input logic [31:0] hi);
    return {hi[29:20], lo[17:12], hi[19:10], lo[11:6], hi[9:0], lo[5:0]};
  endfunction

  function automatic logic [31:0] high_view(input logic [47:0] e);
    return {2'b00, e[47:38], e[31:22], e[15:6]};
  endfunction

  wire wr_sf_idx = bus_we && (bus_addr == A_SF_IDX);
  wire wr_sf_dat = bus_we && (bus_addr == A_SF_DAT);
  wire wr_mt_idx = bus_we && (bus_addr == A_MT_IDX);
  wire wr_mt_dat = bus_we && (bus_addr == A_MT_DAT);

  logic             sf_auto, sf_half;
  logic [SF_AW-1:0] sf_idx;
  logic [17:0]      sf_lo;
  logic             mt_auto, mt_half;
  logic [MT_IW-1:0] mt_idx;
  logic [17:0]      mt_lo;

  wire [SF_AW-1:0] sf_idx_in  = bus_wdata[SF_AW-1:0];
  wire [MT_IW-1:0] mt_idx_in  = bus_wdata[MT_IW-1:0];
  wire [SF_AW-1:0] sf_idx_nxt = (sf_idx == SF_LAST) ? '0 : sf_idx + 1'b1;
  wire [MT_IW-1:0] mt_idx_nxt = (mt_idx == MT_LAST) ? '0 : mt_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_auto <= 1'b0; sf_half <= 1'b0; sf_idx <= '0; sf_lo <= '0;
      sf_we <= 1'b0; sf_waddr <= '0; sf_wdata <= '0;
    end else begin
      sf_we <= 1'b0;
      if (wr_sf_idx) begin
        sf_auto <= bus_wdata[31];
        sf_idx  <= (sf_idx_in > SF_LAST) ? SF_LAST : sf_idx_in;
        sf_half <= 1'b0;
      end else if (wr_sf_dat) begin
        if (!sf_half) begin
          sf_lo   <= low_fields(bus_wdata);
          sf_half <= 1'b1;
        end else begin
          sf_half  <= 1'b0;
          sf_we    <= 1'b1;
          sf_waddr <= sf_idx;
          sf_wdata <= join_entry(sf_lo, bus_wdata);
          if (sf_auto) sf_idx <= sf_idx_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mt_auto <= 1'b0; mt_half <= 1'b0; mt_idx <= '0; mt_lo <= '0;
      mt_we <= 1'b0; mt_waddr <= '0; mt_wdata <= '0;
    end else begin
      mt_we <= 1'b0;
      if (wr_mt_idx) begin
        mt_auto <= bus_wdata[31];
        mt_idx  <= (mt_idx_in > MT_LAST) ? MT_LAST : mt_idx_in;
        mt_half <= 1'b0;
      end else if (wr_mt_dat) begin
        if (!mt_half) begin
          mt_lo   <= low_fields(bus_wdata);
          mt_half <= 1'b1;
        end else begin
          mt_half  <= 1'b0;
          mt_we    <= 1'b1;
          mt_waddr <= MT_AW'(mt_idx) + 1'b1;
          mt_wdata <= join_entry(mt_lo, bus_wdata);
          if (mt_auto) mt_idx <= mt_idx_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_r <= '0; max_g <= '0; max_b <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_MAX_R) max_r <= bus_wdata[15:0];
      if (bus_addr == A_MAX_G) max_g <= bus_wdata[15:0];
      if (bus_addr == A_MAX_B) max_b <= bus_wdata[15:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SF_IDX: begin bus_rdata[31] = sf_auto; bus_rdata[SF_AW-1:0] = sf_idx; end
      A_SF_DAT: bus_rdata = high_view(sf_wdata);
      A_MT_IDX: begin bus_rdata[31] = mt_auto; bus_rdata[MT_IW-1:0] = mt_idx; end
      A_MT_DAT: bus_rdata = high_view(mt_wdata);
      A_MAX_R:  bus_rdata[15:0] = max_r;
      A_MAX_G:  bus_rdata[15:0] = max_g;
      A_MAX_B:  bus_rdata[15:0] = max_b;
      default:  bus_rdata = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sf_we && mt_we)); // R3
  AST_SF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_we |-> ($past(bus_we) && $past(bus_addr) == A_SF_DAT)); // R3
  AST_SF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_we |-> (sf_waddr <= SF_LAST)); // R7
  AST_MT_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mt_we |-> (mt_waddr != '0)); // R8
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_mt_dat && mt_half && !mt_auto) |-> (mt_idx == $past(mt_idx))); // R5
  AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> ($stable(max_r) && $stable(max_g) && $stable(max_b))); // R9

endmodule

// File: tb/sim_gamma_pal_wport.sv
module sim_gamma_pal_wport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        sf_we, mt_we;
  logic [3:0]  sf_waddr;
  logic [9:0]  mt_waddr;
  logic [47:0] sf_wdata, mt_wdata;
  logic [15:0] max_r, max_g, max_b;

  int total = 0, bad = 0;
  bit done = 0;

  logic        c_sf_we, c_mt_we;
  logic [3:0]  c_sf_a;
  logic [9:0]  c_mt_a;
  logic [47:0] c_sf_d, c_mt_d;

  gamma_pal_wport u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(input logic [47:0] e, input logic [31:0] junk);
    logic [31:0] w = junk & 32'hC0F03C0F;
    w[29:24] = e[37:32]; w[19:14] = e[21:16]; w[9:4] = e[5:0];
    return w;
  endfunction

  function automatic logic [31:0] hi_view(input logic [47:0] e);
    return {2'b00, e[47:38], e[31:22], e[15:6]};
  endfunction

  function automatic logic [31:0] hi_word(input logic [47:0] e, input logic [31:0] junk);
    return hi_view(e) | (junk & 32'hC0000000);
  endfunction

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    c_sf_we = sf_we; c_sf_a = sf_waddr; c_sf_d = sf_wdata;
    c_mt_we = mt_we; c_mt_a = mt_waddr; c_mt_d = mt_wdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  // sends one entry; main=1 selects the main table
  task automatic pair(input bit main, input logic [47:0] e, input int exp_a, input string tag);
    logic [3:0] a = main ? 4'd3 : 4'd1;
    wr(a, lo_word(e, $urandom()));
    chk({tag, " R3 no strobe on first word"}, {62'd0, c_sf_we, c_mt_we}, 64'd0);
    wr(a, hi_word(e, $urandom()));
    if (main) begin
      chk({tag, " R3 main strobe"}, {63'd0, c_mt_we}, 64'd1);
      chk({tag, " R8 main addr"}, c_mt_a, exp_a);
      chk({tag, " R2 main entry"}, c_mt_d, e);
    end else begin
      chk({tag, " R3 sf strobe"}, {63'd0, c_sf_we}, 64'd1);
      chk({tag, " R7 sf addr"}, c_sf_a, exp_a);
      chk({tag, " R2 sf entry"}, c_sf_d, e);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [47:0] e, e2;
    int sidx, midx;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a[3:0], r);
      chk("R1 reset readback", r, 0);
    end
    chk("R1 reset strobes", {62'd0, sf_we, mt_we}, 0);
    chk("R1 reset max", {max_r, max_g, max_b}, 0);

    // R9 endpoint registers
    wr(4'd4, 32'hABCD1234);
    wr(4'd5, 32'h0000FFFF);
    wr(4'd6, 32'hFFFF8001);
    chk("R9 max outputs", {max_r, max_g, max_b}, {16'h1234, 16'hFFFF, 16'h8001});
    rd(4'd4, r); chk("R9 max_r readback", r, 32'h1234);
    rd(4'd6, r); chk("R9 max_b readback", r, 32'h8001);

    // R4 R7 superfine stream with wrap
    wr(4'd0, 32'h8000_0000);
    for (int i = 0; i < 10; i++) begin
      e = rnd48();
      pair(0, e, i % 9, "sf stream");
    end
    rd(4'd0, r); chk("R4 sf index readback", r, 32'h8000_0001);
    rd(4'd1, r); chk("R10 sf data readback", r, hi_view(e));
    wr(4'd0, 32'h0000_000F);
    rd(4'd0, r); chk("R7 sf clamp", r, 32'h8);
    e = 48'hFFFF_FFFF_FFFF;
    pair(0, e, 8, "R2 full scale white");

    // R8 full main stream
    wr(4'd2, 32'h8000_0000);
    for (int i = 0; i < 513; i++) begin
      e = rnd48();
      pair(1, e, (i % 512) + 1, "R8 main stream");
    end
    rd(4'd2, r); chk("R8 main index after wrap", r, 32'h8000_0001);
    rd(4'd3, r); chk("R10 main data readback", r, hi_view(e));

    // R5 fixed index
    wr(4'd2, 32'h0000_0005);
    e = rnd48(); pair(1, e, 6, "R5 fixed first");
    e = rnd48(); pair(1, e, 6, "R5 fixed repeat");
    rd(4'd2, r); chk("R5 index unchanged", r, 32'h5);

    // R6 stray word then index write
    wr(4'd3, 32'h3FFF_FFFF);
    wr(4'd2, 32'h8000_000A);
    e = rnd48(); pair(1, e, 11, "R6 realigned");

    // R11 interleaved tables
    wr(4'd0, 32'h8000_0002);
    e = rnd48(); e2 = rnd48();
    wr(4'd3, lo_word(e, 0));
    wr(4'd1, lo_word(e2, 0));
    wr(4'd1, hi_word(e2, 0));
    chk("R11 sf entry", {c_sf_we, c_sf_a, c_sf_d}, {1'b1, 4'd2, e2});
    wr(4'd3, hi_word(e, 0));
    chk("R11 main entry", {c_mt_we, c_mt_a, c_mt_d}, {1'b1, 10'd12, e});

    // R10 unmapped offsets
    wr(4'd15, 32'hFFFF_FFFF);
    chk("R10 unmapped write no strobe", {62'd0, c_sf_we, c_mt_we}, 0);
    rd(4'd15, r); chk("R10 unmapped read", r, 0);
    rd(4'd4, r); chk("R10 unmapped write kept max", r, 32'h1234);

    // random mix
    sidx = 3; midx = 12;
    for (int i = 0; i < 200; i++) begin
      e = rnd48();
      if ($urandom() % 2 == 0) begin
        pair(0, e, sidx, "rand sf");
        sidx = (sidx == 8) ? 0 : sidx + 1;
      end else begin
        pair(1, e, midx + 1, "rand main");
        midx = (midx == 511) ? 0 : midx + 1;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule